// File: doc/BRIEF.md
# Correctable error status logger

This block gathers correctable-error reports from two on-chip memories, a data SRAM and a cache SRAM, and presents them to software as one 32-bit status word. A single-cycle pulse on either error input advances an 8-bit error count. When no earlier error is still pending, the pulse also records which memory reported and some detail bits. The count saturates, and an overflow flag that stays set records that errors were lost. A valid flag tells software that the type and detail fields hold a logged event. Software releases the logged event by writing a one to the valid bit.

The word is reached through a plain register port made of an address, a write strobe, write data and read data. The word answers at offset 0x144 inside the unit's address window. Read data is combinational from the address and the stored state. A report that arrives on a given clock edge is visible on the read port from the next cycle. Only the valid bit is writable. All other fields change only through error reports or reset.

Top module: `ce_status_logger`

## Requirements
- R1: After reset the word reads 0x00000000. Bits 11:10 read as zero at all times.
- R2: Suppose a data SRAM error arrives while the valid flag (bit 0) is clear. The next cycle then reads valid=1, type (bits 15:12)=0 and detail (bits 31:16)=0x0002, which is the write buffer code.
- R3: Suppose a cache SRAM error arrives while valid is clear. The next cycle then reads valid=1 and type=1. Detail bit 16 equals the array-select input (0 for tag, 1 for data), and detail bits 31:17 read as zero.
- R4: Every reported error adds one to the count in bits 9:2. While valid is set and no clear is written, a new error leaves type and detail unchanged.
- R5: A write at offset 0x144 with write-data bit 0 = 1 clears valid in the next cycle. A write with bit 0 = 0, or a write to any other offset, changes nothing.
- R6: If a valid-clearing write and an error fall in the same cycle, the error wins. Valid stays 1, and type and detail are loaded from the new error.
- R7: If both sources report in one cycle, the data SRAM error is the one logged, and the count advances by two.
- R8: If an increment would take the count past 255, the count holds at 255 and the overflow flag (bit 1) sets. Once overflow is set the count no longer changes. The overflow flag and the count are cleared only by reset, and register writes leave them untouched.
- R9: A read at any offset other than 0x144 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dsram_err_i | input | 1 | Data SRAM correctable error pulse |
| csram_err_i | input | 1 | Cache SRAM correctable error pulse |
| csram_arr_i | input | 1 | Cache array select for the error: 0 tag, 1 data |
| reg_addr_i | input | 12 | Register offset within the unit |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |

## Verification
Two of the block's functions can fall in the same cycle: a software clear of valid and the capture of a new error. The second such pair is a report from both sources at once, where the logging priority competes with a count step of two. The bench provokes each pair by asserting the write strobe, or both error inputs, in the very cycle of the report. It then judges the word that follows against a model built from the requirements: valid must still be set, the newest error (data SRAM first) must be logged, and the count must rise by the number of reporting sources. The count is then driven up to the saturation point. This shows that overflow sets exactly on the increment that exceeds 255, and that a write of all ones does not clear it.

// File: rtl/ce_pkg.sv
package ce_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned TYPE_W = 4;
  localparam int unsigned INFO_W = 16;
  localparam int unsigned RSV_W  = WORD_W - INFO_W - TYPE_W - CNT_W - 2;

  typedef enum logic [TYPE_W-1:0] {
    SRC_DSRAM = 4'd0,
    SRC_CSRAM = 4'd1
  } err_src_e;

  localparam logic [INFO_W-1:0] DSRAM_WBUF_INFO = 16'h0002;

  typedef struct packed {
    logic [INFO_W-1:0] info;
    err_src_e          src;
    logic [RSV_W-1:0]  rsv;
    logic [CNT_W-1:0]  cnt;
    logic              ovf;
    logic              vld;
  } status_word_t;
endpackage

// File: rtl/ce_err_counter.sv
module ce_err_counter #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned INC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic [CNT_W:0]   sum;
  logic             cnt_en;

  always_comb begin
    sum    = {1'b0, cnt_q} + {{(CNT_W + 1 - INC_W){1'b0}}, inc_i};
    cnt_en = (inc_i != '0) && !ovf_q;
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    if (cnt_en) begin
      if (sum[CNT_W]) begin
        cnt_d = CNT_MAX;
        ovf_d = 1'b1;
      end else begin
        cnt_d = sum[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R8: overflow stays set
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  // R8: frozen count after overflow
  a_r8_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> $stable(cnt_q));
  // R4: count never decreases outside reset
  a_r4_cnt_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/ce_err_capture.sv
module ce_err_capture
  import ce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dsram_err_i,
  input  logic              csram_err_i,
  input  logic              csram_arr_i,
  input  logic              clr_i,
  output logic              vld_o,
  output err_src_e          src_o,
  output logic [INFO_W-1:0] info_o
);
  logic              vld_q, vld_d;
  err_src_e          src_q, src_d;
  logic [INFO_W-1:0] info_q, info_d;
  logic              any_err, load;

  always_comb begin
    any_err = dsram_err_i | csram_err_i;
    load    = any_err && (!vld_q || clr_i);
    vld_d   = any_err | (vld_q & ~clr_i);
    src_d   = src_q;
    info_d  = info_q;
    if (load) begin
      if (dsram_err_i) begin
        src_d  = SRC_DSRAM;
        info_d = DSRAM_WBUF_INFO;
      end else begin
        src_d  = SRC_CSRAM;
        info_d = {{(INFO_W-1){1'b0}}, csram_arr_i};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_DSRAM;
      info_q <= '0;
    end else if (load) begin
      src_q  <= src_d;
      info_q <= info_d;
    end
  end

  assign vld_o  = vld_q;
  assign src_o  = src_q;
  assign info_o = info_q;

  // R4: logged fields held while an event is pending
  a_r4_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !clr_i) |=> ($stable(src_q) && $stable(info_q)));
  // R6: an error always leaves valid set
  a_r6_err_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (dsram_err_i || csram_err_i) |=> vld_q);
  // R5: clear without error drops valid
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !dsram_err_i && !csram_err_i) |=> !vld_q);
  // R7: data SRAM has priority when both report
  a_r7_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (dsram_err_i && csram_err_i && (!vld_q || clr_i)) |=> (src_q == SRC_DSRAM));
endmodule

// File: rtl/ce_reg_port.sv
module ce_reg_port
  import ce_pkg::*;
#(
  parameter int unsigned     ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h144
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  status_word_t      status_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              clr_o
);
  logic hit;

  always_comb begin
    hit     = (addr_i == REG_OFFSET);
    clr_o   = hit && wr_i && wdata_i[0];
    rdata_o = hit ? WORD_W'(status_i) : '0;
  end

  // R9: off-offset reads return zero
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i != REG_OFFSET) |-> (rdata_o == '0));
  // R5: no clear request from a write of zero
  a_r5_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !wdata_i[0]) |-> !clr_o);
endmodule

// File: rtl/ce_status_logger.sv
module ce_status_logger
  import ce_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h144
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dsram_err_i,
  input  logic              csram_err_i,
  input  logic              csram_arr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o
);
  localparam int unsigned INC_W = 2;

  logic [INC_W-1:0]  inc;
  logic [CNT_W-1:0]  cnt;
  logic              ovf;
  logic              vld;
  logic              clr;
  err_src_e          src;
  logic [INFO_W-1:0] info;
  status_word_t      status;

  always_comb begin
    inc         = {1'b0, dsram_err_i} + {1'b0, csram_err_i};
    status.info = info;
    status.src  = src;
    status.rsv  = '0;
    status.cnt  = cnt;
    status.ovf  = ovf;
    status.vld  = vld;
  end

  ce_err_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (inc),
    .cnt_o (cnt),
    .ovf_o (ovf)
  );

  ce_err_capture u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .dsram_err_i (dsram_err_i),
    .csram_err_i (csram_err_i),
    .csram_arr_i (csram_arr_i),
    .clr_i       (clr),
    .vld_o       (vld),
    .src_o       (src),
    .info_o      (info)
  );

  ce_reg_port #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (reg_addr_i),
    .wr_i     (reg_wr_i),
    .wdata_i  (reg_wdata_i),
    .status_i (status),
    .rdata_o  (reg_rdata_o),
    .clr_o    (clr)
  );

  // R1: reserved bits stay zero on the read port
  a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[11:10] == 2'b00);
endmodule

// File: tb/sim_ce_status_logger.sv
module sim_ce_status_logger;
  localparam logic [11:0] OFS = 12'h144;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        de = 1'b0, ce = 1'b0, carr = 1'b0;
  logic [11:0] addr = OFS;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [31:0] word;
    string       tag;
  } item_t;
  item_t sb[$];

  // reference state
  logic       m_vld = 0, m_ovf = 0;
  int         m_cnt = 0;
  logic [3:0] m_typ = 0;
  logic [15:0] m_info = 0;

  always #2 clk = ~clk;

  ce_status_logger u0 (
    .clk(clk), .rst_n(rst_n),
    .dsram_err_i(de), .csram_err_i(ce), .csram_arr_i(carr),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata)
  );

  function automatic logic [31:0] model_word();
    return {m_info, m_typ, 2'b00, 8'(m_cnt), m_ovf, m_vld};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected word pushed to scoreboard
  task automatic step(input logic d, input logic c, input logic a,
                      input logic w, input logic [11:0] wa,
                      input logic [31:0] wd, input string tag);
    logic clr_hit;
    int   n;
    @(negedge clk);
    de = d; ce = c; carr = a; wr = w; wdata = wd; addr = wa;
    @(posedge clk);
    clr_hit = w && (wa == OFS) && wd[0];
    n = int'(d) + int'(c);
    if ((d || c) && (!m_vld || clr_hit)) begin
      m_typ  = d ? 4'd0 : 4'd1;
      m_info = d ? 16'h0002 : {15'd0, a};
    end
    m_vld = (d || c) || (m_vld && !clr_hit);
    if (n > 0 && !m_ovf) begin
      if (m_cnt + n > 255) begin m_cnt = 255; m_ovf = 1; end
      else m_cnt = m_cnt + n;
    end
    sb.push_back('{model_word(), tag});
    #0;
    @(negedge clk);
    de = 0; ce = 0; wr = 0; wdata = '0; addr = OFS;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(rdata, it.word, it.tag);
      end
    end
  end

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check(rdata, 32'h0, "R1 reset word");
    addr = 12'h140; #1;
    check(rdata, 32'h0, "R9 read at other offset");
    addr = OFS;

    step(1, 0, 0, 0, OFS, 0, "R2 data sram capture");
    step(0, 1, 1, 0, OFS, 0, "R4 no overwrite, count");
    step(1, 0, 0, 0, OFS, 0, "R4 second hold");
    step(0, 0, 0, 1, OFS, 32'hFFFF_FFFE, "R5 write zero ignored");
    step(0, 0, 0, 1, 12'h148, 32'h1, "R5 other offset ignored");
    step(0, 0, 0, 1, OFS, 32'h1, "R5 clear valid");
    step(0, 1, 1, 0, OFS, 0, "R3 cache data array");
    step(0, 0, 0, 1, OFS, 32'h1, "R5 clear again");
    step(0, 1, 0, 0, OFS, 0, "R3 cache tag array");
    step(1, 0, 0, 1, OFS, 32'h1, "R6 clear and error same cycle");
    step(0, 1, 1, 1, OFS, 32'h1, "R6 clear and cache error");
    step(0, 0, 0, 1, OFS, 32'h1, "R5 clear before dual");
    step(1, 1, 1, 0, OFS, 0, "R7 both sources");
    step(0, 1, 0, 1, OFS, 32'h1, "R7 then cache logs");
    @(negedge clk); #1;
    addr = 12'h000; #1;
    check(rdata, 32'h0, "R9 read at offset zero");
    addr = OFS;
    while (m_cnt < 253) step(0, 1, 0, 0, OFS, 0, "R4 count run");
    step(1, 1, 0, 0, OFS, 0, "R8 reach 255 no overflow");
    step(0, 1, 0, 0, OFS, 0, "R8 overflow sets");
    step(1, 1, 0, 0, OFS, 0, "R8 frozen after overflow");
    step(0, 0, 0, 1, OFS, 32'hFFFF_FFFF, "R8 sticky against write");
    step(0, 0, 0, 0, OFS, 0, "R8 idle hold");
    repeat (3) @(negedge clk);
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule